// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial bus engine and a byte-wide nonvolatile storage array. During a page-write transaction, the bus engine hands it data bytes one at a time. Each byte comes with its offset inside the page, and the block holds them in a small page latch. When the transaction's STOP arrives, the block copies the received bytes into the array inside one self-timed write cycle. For the whole of that cycle it raises `busy`. The bus engine uses `busy` to withhold its acknowledge, so a host can poll for completion.

The page is chosen when the transaction opens, and the offset of each byte is supplied by the bus engine, which already wraps it inside the page. Each latch entry has its own valid flag. Only offsets that actually arrived are written, in ascending order, one per clock, at the start of the timed cycle. A write-protect input turns the upper half of the array read-only. The bus framing, the address counter and the read path are outside this block.

Top module: `pwb_page_commit`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy` and `mem_we` are low.
- R2: A byte taken with offset `o` while the page number is `p` is written to array address `{p, o}` (page number in the upper bits, offset in the lowest log2(PAGE_BYTES) bits) with its data unchanged.
- R3: A commit writes exactly one array location for each distinct offset received since the transaction opened, and no other location.
- R4: When a byte arrives at an offset that already holds a byte, the newer byte replaces the older one. The commit writes that offset once, with the newer value.
- R5: A STOP that finds no byte latched starts no write cycle and writes nothing. A latch that has just been committed counts as empty.
- R6: An accepted STOP raises `busy` in the next cycle. `busy` then stays high for exactly WR_CYCLES cycles. All array writes fall inside that window, in strictly ascending address order.
- R7: While `busy` is high, `txn_start`, `byte_vld` and `stop_pls` have no effect. No byte is latched, the page number is kept, and no further cycle is queued.
- R8: If `wp` is high during the STOP cycle and the page number's top bit is 1 (upper half), the STOP writes nothing, raises no `busy`, and discards the latched bytes. With `wp` low, or with a lower-half page, the commit runs normally.
- R9: A byte strobe in the same cycle as an accepted STOP is included in that commit.
- R10: `txn_start` (with `busy` low and no STOP in the same cycle) loads `txn_page` and discards all previously latched bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| txn_start | input | 1 | Opens a page-write transaction: loads the page, empties the latch |
| txn_page | input | ADDR_W-log2(PAGE_BYTES) | Page number, upper address bits of the transaction |
| byte_vld | input | 1 | One data byte is offered this cycle |
| byte_off | input | log2(PAGE_BYTES) | Offset of the offered byte within the page |
| byte_data | input | 8 | Offered data byte |
| stop_pls | input | 1 | STOP seen on the bus: commit request |
| wp | input | 1 | Write protect for the upper half of the array |
| busy | output | 1 | Timed write cycle in progress; bus engine must not acknowledge |
| mem_we | output | 1 | Array write enable, one byte per cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two things can fall on the same clock edge: a byte strobe and the STOP that closes the transaction. The bench raises `byte_vld` and `stop_pls` together on one edge. It then expects that byte to land in the array along with the bytes sent earlier, and it expects a write count that includes it. The same edge also meets protection: a STOP for a protected upper-half page must write nothing and raise no `busy`. This is checked across every page with `wp` both low and high. A second same-window case drives a new transaction, a byte and a STOP while `busy` is high. Afterwards the array, the write count and a later empty STOP must all show that none of them took effect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } pwb_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int unsigned NUM = 16,
  parameter int unsigned DW  = 8,
  localparam int unsigned OW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          kill,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          pend
);
  logic [NUM-1:0]         vld_q;
  logic [NUM-1:0]         vld_n;
  logic [NUM-1:0]         hit;
  logic [NUM-1:0][DW-1:0] data_q;

  // per-entry next state: a write hit sets the flag unless the whole latch is killed
  for (genvar gi = 0; gi < NUM; gi++) begin : g_ent
    assign hit[gi]   = wr_en && (wr_off == OW'(gi));
    assign vld_n[gi] = !kill && (hit[gi] || (vld_q[gi] && !soft_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (hit[i]) begin
          data_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign pend     = wr_en || ((|vld_q) && !soft_clr);

  // a strobe that is not killed must leave its offset valid
  AST_HIT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kill) |=> vld_q[$past(wr_off)]) else $error("hit lost"); // R2
endmodule

// File: rtl/pwb_wr_timer.sv
module pwb_wr_timer #(
  parameter int unsigned CYC = 625000,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start) begin
      cnt_n = CW'(CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
  import pwb_pkg::*;
#(
  parameter int unsigned NUM       = 16,
  parameter int unsigned WR_CYCLES = 625000,
  localparam int unsigned OW  = $clog2(NUM),
  localparam int unsigned CYC = (WR_CYCLES > NUM) ? WR_CYCLES : NUM + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_pls,
  input  logic          pend,
  input  logic          prot,
  output logic          busy,
  output logic          scan_en,
  output logic [OW-1:0] scan_idx,
  output logic          kill
);
  pwb_state_e    state_q;
  pwb_state_e    state_n;
  logic [OW-1:0] idx_q;
  logic [OW-1:0] idx_n;
  logic          go;
  logic          drop;
  logic          scan_last;
  logic          tmr_zero;

  assign go        = stop_pls && (state_q == ST_IDLE) && pend && !prot;
  assign drop      = stop_pls && (state_q == ST_IDLE) && pend && prot;
  assign scan_last = (state_q == ST_SCAN) && (idx_q == OW'(NUM - 1));

  pwb_wr_timer #(.CYC(CYC)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .zero  (tmr_zero)
  );

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        idx_n = '0;
        if (go) begin
          state_n = ST_SCAN;
        end
      end
      ST_SCAN: begin
        idx_n = idx_q + 1'b1;
        if (scan_last) begin
          state_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          state_n = ST_IDLE;
        end
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign scan_en  = (state_q == ST_SCAN);
  assign scan_idx = idx_q;
  assign kill     = drop || scan_last;

  // the scan of all offsets must end well before the timed cycle expires
  AST_SCAN_BEFORE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> !tmr_zero) else $error("timer expired in scan"); // R6
endmodule

// File: rtl/pwb_page_commit.sv
module pwb_page_commit
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned WR_CYCLES  = 625000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                txn_start,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] txn_page,
  input  logic                                byte_vld,
  input  logic [$clog2(PAGE_BYTES)-1:0]        byte_off,
  input  logic [7:0]                          byte_data,
  input  logic                                stop_pls,
  input  logic                                wp,
  output logic                                busy,
  output logic                                mem_we,
  output logic [ADDR_W-1:0]                   mem_addr,
  output logic [7:0]                          mem_wdata
);
  localparam int unsigned OW = $clog2(PAGE_BYTES);
  localparam int unsigned PW = ADDR_W - OW;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [PW-1:0]     page_q;
  logic              txn_acc;
  logic              byte_acc;
  logic              prot;
  logic              pend;
  logic              kill;
  logic              scan_en;
  logic [OW-1:0]     scan_idx;
  logic              rd_valid;
  logic [BYTE_W-1:0] rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign txn_acc  = txn_start && !busy && !stop_pls;
  assign byte_acc = byte_vld && !busy;
  assign prot     = wp && page_q[PW-1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      page_q <= '0;
    end else if (txn_acc) begin
      page_q <= txn_page;
    end
  end

  pwb_page_latch #(.NUM(PAGE_BYTES), .DW(BYTE_W)) latch_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .soft_clr (txn_acc),
    .kill     (kill),
    .wr_en    (byte_acc),
    .wr_off   (byte_off),
    .wr_data  (byte_data),
    .rd_idx   (scan_idx),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .pend     (pend)
  );

  pwb_commit_seq #(.NUM(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) seq_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .stop_pls (stop_pls),
    .pend     (pend),
    .prot     (prot),
    .busy     (busy),
    .scan_en  (scan_en),
    .scan_idx (scan_idx),
    .kill     (kill)
  );

  assign mem_we    = scan_en && rd_valid;
  assign mem_addr  = {page_q, scan_idx};
  assign mem_wdata = rd_data;

  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> busy) else $error("write outside cycle"); // R6
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(busy) |-> $past(stop_pls)) else $error("cycle without stop"); // R6
  AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(busy) |-> $past(pend)) else $error("cycle on empty latch"); // R5
  AST_PROT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(busy) |-> !$past(prot)) else $error("cycle on protected page"); // R8
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && $past(busy)) |-> $stable(page_q)) else $error("page moved while busy"); // R7
endmodule

// File: tb/pwb_page_commit_tb_top.sv
module pwb_page_commit_tb_top;
  localparam int AW  = 8;
  localparam int PB  = 16;
  localparam int WRC = 40;
  localparam int NA  = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       txn_start;
  logic [3:0] txn_page;
  logic       byte_vld;
  logic [3:0] byte_off;
  logic [7:0] byte_data;
  logic       stop_pls;
  logic       wp;
  logic       busy;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  pwb_page_commit #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) dut_i (
    .clk (clk), .rst_n (rst_n), .txn_start (txn_start), .txn_page (txn_page),
    .byte_vld (byte_vld), .byte_off (byte_off), .byte_data (byte_data),
    .stop_pls (stop_pls), .wp (wp), .busy (busy), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata)
  );

  int         total = 0;
  int         bad = 0;
  logic [7:0] arr [NA];
  logic [7:0] exp_mem [NA];
  int         wr_cnt = 0;
  int         last_a = -1;
  bit         order_bad = 1'b0;

  // bench-side array: captures every write strobe
  always @(negedge clk) begin
    if (!busy) last_a = -1;
    if (mem_we) begin
      arr[mem_addr] = mem_wdata;
      wr_cnt++;
      if (int'(mem_addr) <= last_a) order_bad = 1'b1;
      last_a = int'(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int mism = 0;
    for (int a = 0; a < NA; a++) if (arr[a] !== exp_mem[a]) mism++;
    chk(mism == 0, tag, mism, 0);
  endtask

  task automatic start_txn(input int pg);
    txn_start = 1'b1; txn_page = 4'(pg);
    @(negedge clk);
    txn_start = 1'b0;
  endtask

  task automatic put(input int off, input int d);
    byte_vld = 1'b1; byte_off = 4'(off); byte_data = 8'(d);
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic finish_commit(input int exp_w, input bit exp_cyc, input string tag,
                               input bit with_b, input int boff, input int bdat);
    int w0 = wr_cnt;
    int n  = 0;
    order_bad = 1'b0;
    stop_pls = 1'b1;
    if (with_b) begin
      byte_vld = 1'b1; byte_off = 4'(boff); byte_data = 8'(bdat);
    end
    @(negedge clk);
    stop_pls = 1'b0; byte_vld = 1'b0;
    chk(busy == exp_cyc, {tag, " R6 busy after stop"}, int'(busy), int'(exp_cyc));
    while (busy) begin
      n++;
      @(negedge clk);
    end
    if (exp_cyc) chk(n == WRC, {tag, " R6 busy length"}, n, WRC);
    chk(wr_cnt - w0 == exp_w, {tag, " R3 write count"}, wr_cnt - w0, exp_w);
    chk(!order_bad, {tag, " R6 ascending order"}, int'(order_bad), 0);
    cmp_mem({tag, " R2 array contents"});
  endtask

  task automatic run_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 after release", int'(busy), 0);

    // R2/R3/R8: sweep every page with protect low and high
    for (int pg = 0; pg < 16; pg++) begin
      for (int w = 0; w < 2; w++) begin
        int  n  = ((pg * 3 + w) % 16) + 1;
        bit  pr = (w == 1) && (pg >= 8);
        wp = 1'(w);
        start_txn(pg);
        for (int k = 0; k < n; k++) begin
          int off = (pg * 5 + k * 7) % 16;
          int d   = (pg * 37 + k * 11 + w * 101) & 255;
          put(off, d);
          if (!pr) exp_mem[pg * 16 + off] = 8'(d);
        end
        finish_commit(pr ? 0 : n, !pr, pr ? "R8 protected" : "R8 sweep", 1'b0, 0, 0);
        wp = 1'b0;
      end
    end

    // R4: 20 bytes wrap the offsets; the later four overwrite
    start_txn(5);
    for (int k = 0; k < 20; k++) begin
      put(k % 16, 200 + k);
    end
    for (int o = 0; o < 16; o++) exp_mem[5 * 16 + o] = 8'((o < 4) ? 216 + o : 200 + o);
    finish_commit(16, 1'b1, "R4 rollover", 1'b0, 0, 0);

    // R5: empty STOP right after a commit, and after a fresh open
    finish_commit(0, 1'b0, "R5 after commit", 1'b0, 0, 0);
    start_txn(3);
    finish_commit(0, 1'b0, "R5 fresh open", 1'b0, 0, 0);

    // R9: byte strobe on the same edge as STOP
    start_txn(6);
    put(2, 8'h11);
    exp_mem[6 * 16 + 2] = 8'h11;
    exp_mem[6 * 16 + 9] = 8'h99;
    finish_commit(2, 1'b1, "R9 same-edge byte", 1'b1, 9, 8'h99);

    // R10: txn_start discards earlier bytes
    start_txn(7);
    put(0, 8'hE0); put(1, 8'hE1);
    start_txn(1);
    put(12, 8'h5C);
    exp_mem[1 * 16 + 12] = 8'h5C;
    finish_commit(1, 1'b1, "R10 reopen clears", 1'b0, 0, 0);

    // R7: activity during busy is ignored
    begin
      int w0 = wr_cnt;
      start_txn(2);
      put(1, 8'hA5);
      exp_mem[2 * 16 + 1] = 8'hA5;
      stop_pls = 1'b1;
      @(negedge clk);
      stop_pls = 1'b0;
      chk(busy == 1'b1, "R7 cycle started", int'(busy), 1);
      start_txn(9);
      put(3, 8'h77);
      stop_pls = 1'b1;
      @(negedge clk);
      stop_pls = 1'b0;
      while (busy) @(negedge clk);
      chk(wr_cnt - w0 == 1, "R7 one write only", wr_cnt - w0, 1);
      cmp_mem("R7 array after busy");
    end
    finish_commit(0, 1'b0, "R7 nothing latched while busy", 1'b0, 0, 0);
    put(4, 8'h3C);
    exp_mem[2 * 16 + 4] = 8'h3C;
    finish_commit(1, 1'b1, "R7 page kept", 1'b0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; txn_start = 1'b0; txn_page = '0; byte_vld = 1'b0;
    byte_off = '0; byte_data = '0; stop_pls = 1'b0; wp = 1'b0;
    for (int a = 0; a < NA; a++) begin
      arr[a] = 8'h00;
      exp_mem[a] = 8'h00;
    end
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule